// File: doc/BRIEF.md
# Pivot Row Router with Retirement Queue

This block sits between the feeders of a sparse LU factorization engine and its two update lanes: one lane holds the lower-triangular part of the matrix (below the diagonal) and the other holds the upper-triangular part (on or above it). Rows are never exchanged in storage. A permutation table maps each logical row to the physical row it occupies after pivoting. A pivot command exchanges two table entries. From then on, each incoming element is steered using the remapped row index.

Every element that enters is sent to one of four places:

- **Retirement queue.** An element is retired when no later step can change its value. The retirement queue streams elements out in arrival order.
- **Own lane, directly.** This applies when the element's lane is the same under its logical row and its physical row.
- **Diversion FIFO.** This applies when the remapping moves the element across the diagonal. The FIFO holds the element until the destination lane has a free slot.

Direct traffic always goes ahead of drained traffic, so the routing of pivots never stalls the update lanes.

Top module: `pr_route`

## Requirements
- R1: After reset, the permutation table is the identity, the current step is 0, and lo_valid_o, up_valid_o and ret_valid_o are all low.
- R2: A pivot command with piv_row_i different from piv_step_i exchanges the table entries of those two rows in one cycle. Elements presented from the next cycle on see the exchanged mapping. Elements in the same cycle use the old mapping. Every pivot command loads piv_step_i as the current step.
- R3: A non-final element whose physical row (the table entry of in_row_i) is greater than in_col_i leaves on the lo lane. Its row field is replaced by the physical row.
- R4: A non-final element whose physical row is less than or equal to in_col_i leaves on the up lane. Its row field is replaced by the physical row.
- R5: A pivot command with piv_row_i equal to piv_step_i leaves the table unchanged, so routing after it is the same as before it.
- R6: An element is final when in_col_i is less than the current step or its physical row is less than the current step. A final element goes to the retirement queue and no lane. The queue emits elements in arrival order and holds ret_* stable while ret_ready_i is low.
- R7: A non-final element is diverted when its lane under the physical row differs from its lane under in_row_i. A diverted element enters a FIFO of DIV_DEPTH entries and appears later on its destination lane. in_ready_o is low for such an element while that FIFO is full.
- R8: A diverted element reaches a lane only in a cycle in which no direct element is presented to that lane. Diverted elements leave in arrival order.
- R9: in_ready_o is low for a final element while the retirement queue holds RET_DEPTH entries.
- R10: For a direct element, in_ready_o equals the ready input of its destination lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| piv_valid_i | input | 1 | Pivot command strobe |
| piv_step_i | input | IW | Current elimination step |
| piv_row_i | input | IW | Row chosen as pivot for that step |
| in_valid_i | input | 1 | Element valid |
| in_row_i | input | IW | Logical row index of the element |
| in_col_i | input | IW | Column index of the element |
| in_data_i | input | DW | Element value |
| in_ready_o | output | 1 | Element accepted |
| lo_valid_o | output | 1 | Lower lane element valid |
| lo_ready_i | input | 1 | Lower lane can accept |
| lo_row_o | output | IW | Physical row toward lower lane |
| lo_col_o | output | IW | Column toward lower lane |
| lo_data_o | output | DW | Value toward lower lane |
| up_valid_o | output | 1 | Upper lane element valid |
| up_ready_i | input | 1 | Upper lane can accept |
| up_row_o | output | IW | Physical row toward upper lane |
| up_col_o | output | IW | Column toward upper lane |
| up_data_o | output | DW | Value toward upper lane |
| ret_valid_o | output | 1 | Retired element valid |
| ret_ready_i | input | 1 | Retirement sink can accept |
| ret_row_o | output | IW | Physical row of retired element |
| ret_col_o | output | IW | Column of retired element |
| ret_data_o | output | DW | Value of retired element |

## Verification
Several properties are checked on every cycle:

- The table remains a permutation.
- A no-op pivot leaves the table untouched.
- A real pivot changes the table.
- Each lane only ever carries elements from its own side of the diagonal.
- A stalled retirement output does not move.

Other behaviour can only be shown by the bench scenarios, because it spans cycles and depends on the order of earlier elements:

- which physical row an element receives after a sequence of pivots;
- the arrival order of diverted and retired elements;
- the priority of direct traffic over drained traffic;
- the backpressure seen at the full depth of each queue.

// File: rtl/pr_pkg.sv
package pr_pkg;
  typedef enum logic [1:0] {
    DST_LO  = 2'd0,
    DST_UP  = 2'd1,
    DST_DIV = 2'd2,
    DST_RET = 2'd3
  } dst_e;
endpackage

// File: rtl/pr_map.sv
module pr_map #(
  parameter int N_ROWS = 8,
  parameter int IW     = $clog2(N_ROWS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 swap_i,
  input  logic [IW-1:0]        a_i,
  input  logic [IW-1:0]        b_i,
  input  logic [IW-1:0]        rd_idx_i,
  output logic [IW-1:0]        rd_row_o,
  output logic [N_ROWS*IW-1:0] tbl_o
);
  logic [IW-1:0] tbl_q [N_ROWS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < N_ROWS; k++) tbl_q[k] <= IW'(k);
    end else if (swap_i) begin
      tbl_q[a_i] <= tbl_q[b_i];
      tbl_q[b_i] <= tbl_q[a_i];
    end
  end

  assign rd_row_o = tbl_q[rd_idx_i];

  for (genvar g = 0; g < N_ROWS; g++) begin : g_flat
    assign tbl_o[g*IW +: IW] = tbl_q[g];
  end
endmodule

// File: rtl/pr_fifo.sv
module pr_fifo #(
  parameter type T     = logic,
  parameter int  DEPTH = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic push_i,
  input  T     din_i,
  input  logic pop_i,
  output T     dout_o,
  output logic full_o,
  output logic empty_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  T              mem_q [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q;

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign dout_o  = mem_q[rp_q];

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wp_q] <= din_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wp_q <= (wp_q == AW'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
      if (pop_i)  rp_q <= (rp_q == AW'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
      if (push_i && !pop_i)      cnt_q <= cnt_q + 1'b1;
      else if (!push_i && pop_i) cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/pr_route.sv
module pr_route
  import pr_pkg::*;
#(
  parameter int N_ROWS    = 8,
  parameter int DW        = 16,
  parameter int DIV_DEPTH = 4,
  parameter int RET_DEPTH = 4,
  localparam int IW       = $clog2(N_ROWS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          piv_valid_i,
  input  logic [IW-1:0] piv_step_i,
  input  logic [IW-1:0] piv_row_i,
  input  logic          in_valid_i,
  input  logic [IW-1:0] in_row_i,
  input  logic [IW-1:0] in_col_i,
  input  logic [DW-1:0] in_data_i,
  output logic          in_ready_o,
  output logic          lo_valid_o,
  input  logic          lo_ready_i,
  output logic [IW-1:0] lo_row_o,
  output logic [IW-1:0] lo_col_o,
  output logic [DW-1:0] lo_data_o,
  output logic          up_valid_o,
  input  logic          up_ready_i,
  output logic [IW-1:0] up_row_o,
  output logic [IW-1:0] up_col_o,
  output logic [DW-1:0] up_data_o,
  output logic          ret_valid_o,
  input  logic          ret_ready_i,
  output logic [IW-1:0] ret_row_o,
  output logic [IW-1:0] ret_col_o,
  output logic [DW-1:0] ret_data_o
);
  typedef struct packed {
    logic          lo;
    logic [IW-1:0] row;
    logic [IW-1:0] col;
    logic [DW-1:0] data;
  } ent_t;

  logic [IW-1:0]        step_q;
  logic [IW-1:0]        prow;
  logic [N_ROWS*IW-1:0] map_flat;
  logic                 is_final, to_lo, home_lo;
  dst_e                 dst;
  logic                 fire;
  ent_t                 in_ent, div_head, ret_head;
  logic                 div_full, div_empty, div_push, div_pop;
  logic                 ret_full, ret_empty, ret_push, ret_pop;
  logic                 direct_lo, direct_up, drain_lo, drain_up;

  pr_map #(.N_ROWS(N_ROWS), .IW(IW)) u_map (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .swap_i   (piv_valid_i && (piv_step_i != piv_row_i)),
    .a_i      (piv_step_i),
    .b_i      (piv_row_i),
    .rd_idx_i (in_row_i),
    .rd_row_o (prow),
    .tbl_o    (map_flat)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          step_q <= '0;
    else if (piv_valid_i) step_q <= piv_step_i;
  end

  // classification uses the table and step from before any same-cycle pivot
  assign is_final = (in_col_i < step_q) || (prow < step_q);
  assign to_lo    = prow > in_col_i;
  assign home_lo  = in_row_i > in_col_i;

  always_comb begin
    if (is_final)              dst = DST_RET;
    else if (to_lo != home_lo) dst = DST_DIV;
    else if (to_lo)            dst = DST_LO;
    else                       dst = DST_UP;
  end

  always_comb begin
    unique case (dst)
      DST_LO:  in_ready_o = lo_ready_i;
      DST_UP:  in_ready_o = up_ready_i;
      DST_DIV: in_ready_o = !div_full;
      default: in_ready_o = !ret_full;
    endcase
  end

  assign fire   = in_valid_i && in_ready_o;
  assign in_ent = '{lo: to_lo, row: prow, col: in_col_i, data: in_data_i};

  assign div_push = fire && (dst == DST_DIV);
  assign ret_push = fire && (dst == DST_RET);

  pr_fifo #(.T(ent_t), .DEPTH(DIV_DEPTH)) u_div (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (div_push),
    .din_i   (in_ent),
    .pop_i   (div_pop),
    .dout_o  (div_head),
    .full_o  (div_full),
    .empty_o (div_empty)
  );

  pr_fifo #(.T(ent_t), .DEPTH(RET_DEPTH)) u_ret (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (ret_push),
    .din_i   (in_ent),
    .pop_i   (ret_pop),
    .dout_o  (ret_head),
    .full_o  (ret_full),
    .empty_o (ret_empty)
  );

  // direct traffic owns a lane; diverted entries fill idle slots only
  assign direct_lo = in_valid_i && (dst == DST_LO);
  assign direct_up = in_valid_i && (dst == DST_UP);
  assign drain_lo  = !div_empty &&  div_head.lo && !direct_lo;
  assign drain_up  = !div_empty && !div_head.lo && !direct_up;
  assign div_pop   = (drain_lo && lo_ready_i) || (drain_up && up_ready_i);

  assign lo_valid_o = direct_lo || drain_lo;
  assign lo_row_o   = direct_lo ? prow      : div_head.row;
  assign lo_col_o   = direct_lo ? in_col_i  : div_head.col;
  assign lo_data_o  = direct_lo ? in_data_i : div_head.data;

  assign up_valid_o = direct_up || drain_up;
  assign up_row_o   = direct_up ? prow      : div_head.row;
  assign up_col_o   = direct_up ? in_col_i  : div_head.col;
  assign up_data_o  = direct_up ? in_data_i : div_head.data;

  assign ret_valid_o = !ret_empty;
  assign ret_pop     = ret_valid_o && ret_ready_i;
  assign ret_row_o   = ret_head.row;
  assign ret_col_o   = ret_head.col;
  assign ret_data_o  = ret_head.data;
endmodule

// File: rtl/pr_route_chk.sv
module pr_route_chk #(
  parameter int N_ROWS = 8,
  parameter int IW     = 3,
  parameter int DW     = 16
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 piv_valid_i,
  input logic [IW-1:0]        piv_step_i,
  input logic [IW-1:0]        piv_row_i,
  input logic [N_ROWS*IW-1:0] map_flat,
  input logic                 lo_valid_o,
  input logic [IW-1:0]        lo_row_o,
  input logic [IW-1:0]        lo_col_o,
  input logic                 up_valid_o,
  input logic [IW-1:0]        up_row_o,
  input logic [IW-1:0]        up_col_o,
  input logic                 ret_valid_o,
  input logic                 ret_ready_i,
  input logic [IW-1:0]        ret_row_o,
  input logic [DW-1:0]        ret_data_o
);
  logic [N_ROWS-1:0] seen;

  always_comb begin
    seen = '0;
    for (int k = 0; k < N_ROWS; k++) seen[map_flat[k*IW +: IW]] = 1'b1;
  end

  assert_perm_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(seen) == N_ROWS);

  assert_swap_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    piv_valid_i && (piv_step_i != piv_row_i) |=> map_flat != $past(map_flat));

  assert_noop_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    piv_valid_i && (piv_step_i == piv_row_i) |=> $stable(map_flat));

  assert_lo_side_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lo_valid_o |-> lo_row_o > lo_col_o);

  assert_up_side_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    up_valid_o |-> up_row_o <= up_col_o);

  assert_ret_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ret_valid_o && !ret_ready_i |=> ret_valid_o && $stable(ret_data_o) && $stable(ret_row_o));
endmodule

bind pr_route pr_route_chk #(.N_ROWS(N_ROWS), .IW(IW), .DW(DW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .piv_valid_i (piv_valid_i),
  .piv_step_i  (piv_step_i),
  .piv_row_i   (piv_row_i),
  .map_flat    (map_flat),
  .lo_valid_o  (lo_valid_o),
  .lo_row_o    (lo_row_o),
  .lo_col_o    (lo_col_o),
  .up_valid_o  (up_valid_o),
  .up_row_o    (up_row_o),
  .up_col_o    (up_col_o),
  .ret_valid_o (ret_valid_o),
  .ret_ready_i (ret_ready_i),
  .ret_row_o   (ret_row_o),
  .ret_data_o  (ret_data_o)
);

// File: tb/sim_pr_route.sv
`timescale 1ns/1ps
module sim_pr_route;
  localparam int N  = 8;
  localparam int IW = 3;
  localparam int DW = 16;
  localparam int DD = 4;
  localparam int RD = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic          piv_v = 0, in_v = 0, lo_rdy = 0, up_rdy = 0, ret_rdy = 0;
  logic [IW-1:0] piv_s = 0, piv_r = 0, in_r = 0, in_c = 0;
  logic [DW-1:0] in_d = 0;
  logic          in_rdy, lo_v, up_v, ret_v;
  logic [IW-1:0] lo_r, lo_c, up_r, up_c, ret_r, ret_c;
  logic [DW-1:0] lo_d, up_d, ret_d;

  pr_route #(.N_ROWS(N), .DW(DW), .DIV_DEPTH(DD), .RET_DEPTH(RD)) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .piv_valid_i(piv_v), .piv_step_i(piv_s), .piv_row_i(piv_r),
    .in_valid_i(in_v), .in_row_i(in_r), .in_col_i(in_c), .in_data_i(in_d), .in_ready_o(in_rdy),
    .lo_valid_o(lo_v), .lo_ready_i(lo_rdy), .lo_row_o(lo_r), .lo_col_o(lo_c), .lo_data_o(lo_d),
    .up_valid_o(up_v), .up_ready_i(up_rdy), .up_row_o(up_r), .up_col_o(up_c), .up_data_o(up_d),
    .ret_valid_o(ret_v), .ret_ready_i(ret_rdy), .ret_row_o(ret_r), .ret_col_o(ret_c), .ret_data_o(ret_d)
  );

  typedef struct {bit lo; int row; int col; int data;} m_t;
  m_t divq[$];
  m_t retq[$];
  int map [N];
  int step;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int route_kind(int r, int c, output int pr);
    bit fin, tlo, hlo;
    pr  = map[r];
    fin = (c < step) || (pr < step);
    tlo = pr > c;
    hlo = r > c;
    if (fin) return 3;
    if (tlo != hlo) return 2;
    return tlo ? 0 : 1;
  endfunction

  task automatic lane_chk(bit is_lo, int kind, int pr, logic v, int r, int c, int d,
                          logic rdy, ref bit pop);
    string tag = is_lo ? "R3" : "R4";
    if (in_v && kind == (is_lo ? 0 : 1)) begin
      chk(v == 1, tag, v, 1);
      chk(r == pr && c == int'(in_c) && d == int'(in_d), tag, d, int'(in_d));
    end else if (divq.size() > 0 && divq[0].lo == is_lo) begin
      chk(v == 1, "R8", v, 1);
      chk(r == divq[0].row && c == divq[0].col && d == divq[0].data, "R8", d, divq[0].data);
      if (rdy) pop = 1;
    end else begin
      chk(v == 0, tag, v, 0);
    end
  endtask

  // evaluates one cycle with the inputs already set, then advances to the next negedge
  task automatic cyc();
    int pr, kind;
    bit exp_rdy, pop;
    #1;
    kind = route_kind(int'(in_r), int'(in_c), pr);
    case (kind)
      0: exp_rdy = lo_rdy;
      1: exp_rdy = up_rdy;
      2: exp_rdy = divq.size() < DD;
      default: exp_rdy = retq.size() < RD;
    endcase
    if (in_v)
      chk(in_rdy == exp_rdy, kind == 2 ? "R7" : kind == 3 ? "R9" : "R10", in_rdy, exp_rdy);
    pop = 0;
    lane_chk(1, kind, pr, lo_v, int'(lo_r), int'(lo_c), int'(lo_d), lo_rdy, pop);
    lane_chk(0, kind, pr, up_v, int'(up_r), int'(up_c), int'(up_d), up_rdy, pop);
    if (pop) void'(divq.pop_front());
    chk(ret_v == (retq.size() > 0), "R6", ret_v, retq.size() > 0);
    if (retq.size() > 0) begin
      chk(int'(ret_d) == retq[0].data && int'(ret_r) == retq[0].row && int'(ret_c) == retq[0].col,
          "R6", int'(ret_d), retq[0].data);
      if (ret_rdy) void'(retq.pop_front());
    end
    if (in_v && exp_rdy) begin
      if (kind == 2) divq.push_back('{pr > int'(in_c), pr, int'(in_c), int'(in_d)});
      if (kind == 3) retq.push_back('{0, pr, int'(in_c), int'(in_d)});
    end
    if (piv_v) begin
      if (piv_s != piv_r) begin
        int t = map[piv_s];
        map[piv_s] = map[piv_r];
        map[piv_r] = t;
      end
      step = int'(piv_s);
    end
    @(negedge clk);
  endtask

  task automatic idle();
    piv_v = 0; in_v = 0;
  endtask

  task automatic put(int r, int c, int d);
    piv_v = 0; in_v = 1; in_r = IW'(r); in_c = IW'(c); in_d = DW'(d);
  endtask

  task automatic pivot(int s, int r);
    in_v = 0; piv_v = 1; piv_s = IW'(s); piv_r = IW'(r);
  endtask

  initial begin
    repeat (30000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < N; k++) map[k] = k;
    step = 0;
    #20;
    // R1: outputs idle in reset
    chk(lo_v == 0 && up_v == 0 && ret_v == 0, "R1", lo_v | up_v | ret_v, 0);
    @(negedge clk); rst_n = 1; @(negedge clk);

    // R1: identity map, step 0 -> upper lane, row unchanged
    lo_rdy = 1; up_rdy = 1; ret_rdy = 1;
    put(2, 5, 16'h0a01); #1;
    chk(up_v && up_r == 2 && !ret_v, "R1", int'(up_r), 2);
    cyc();
    put(6, 1, 16'h0a02); #1;
    chk(lo_v && lo_r == 6, "R1", int'(lo_r), 6);
    cyc();

    // R2: swap rows 0 and 5; same-cycle element still sees old map
    pivot(0, 5); in_v = 1; in_r = 5; in_c = 3; in_d = 16'h0b00; #1;
    chk(lo_v && lo_r == 5, "R2", int'(lo_r), 5);
    cyc();
    // R7: rows 0 and 5 now cross the diagonal, lower lane stalled -> fill FIFO
    lo_rdy = 0;
    for (int k = 0; k < DD; k++) begin
      put(0, 3, 16'h0b10 + k); cyc();
    end
    put(0, 4, 16'h0b20); #1;
    chk(in_rdy == 0, "R7", in_rdy, 0);
    cyc();
    // R8: direct lower traffic blocks drain, then drain follows in order
    lo_rdy = 1;
    put(7, 2, 16'h0b30); #1;
    chk(lo_v && lo_d == 16'h0b30, "R8", int'(lo_d), 16'h0b30);
    cyc();
    idle(); #1;
    chk(lo_v && lo_r == 5 && lo_d == 16'h0b10, "R8", int'(lo_d), 16'h0b10);
    cyc();
    repeat (DD) cyc();

    // R5: no-op pivot keeps map (row 0 still maps to 5), step 0
    pivot(0, 0); cyc();
    put(6, 6, 16'h0c00); #1;
    chk(up_v && up_r == 6, "R5", int'(up_r), 6);
    cyc();
    put(0, 2, 16'h0c01); cyc();
    repeat (2) begin idle(); cyc(); end

    // R6/R9: step 4 makes columns below 4 final; stall sink and fill queue
    pivot(4, 4); cyc();
    ret_rdy = 0;
    for (int k = 0; k < RD; k++) begin
      put(6, k, 16'h0d00 + k); cyc();
    end
    put(7, 1, 16'h0d10); #1;
    chk(in_rdy == 0, "R9", in_rdy, 0);
    cyc();
    idle(); cyc(); cyc();
    ret_rdy = 1; #1;
    chk(ret_v && ret_d == 16'h0d00, "R6", int'(ret_d), 16'h0d00);
    repeat (RD + 1) cyc();

    // random phase
    void'($urandom(32'd20240611));
    for (int n = 0; n < 4000; n++) begin
      piv_v   = ($urandom % 8) == 0;
      piv_s   = IW'($urandom % 4);
      piv_r   = IW'($urandom % N);
      in_v    = ($urandom % 4) != 0;
      in_r    = IW'($urandom % N);
      in_c    = IW'($urandom % N);
      in_d    = DW'($urandom);
      lo_rdy  = ($urandom % 4) != 0;
      up_rdy  = ($urandom % 4) != 0;
      ret_rdy = ($urandom % 2) != 0;
      cyc();
    end
    idle(); lo_rdy = 1; up_rdy = 1; ret_rdy = 1;
    repeat (2 * (DD + RD)) cyc();

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule